// File: doc/BRIEF.md
# Write-Through Snooping Cache Controller

This block is the private data cache of one processor in a machine where two or more processors share one memory bus. It is direct-mapped and holds sixteen one-word lines. Each line is either valid or invalid and carries no dirty state. A load that hits is answered in the cycle it is presented. A load that misses asks for the bus, waits for a grant, reads the word from memory and fills the line.

Every store goes out on the bus and through to memory. The processor is stalled until memory accepts the write. A store that hits also updates the local word. A store that misses does not allocate a line.

The controller watches write transfers made on the bus by the other masters. If one of them targets a line it holds, it drops that line, so that the next local load fetches the new value from memory. Transfers tagged with the controller's own master number are ignored. When a snoop kill and a local access touch the same line in the same cycle, the kill is applied first.

Top module: `wtsnoop_cache`

## Requirements
- R1: After reset every line is invalid, and `cpu_ready`, `bus_req` and `bus_valid` are low. The first load of any address therefore misses.
- R2: A load whose index (address bits [3:0]) holds a valid line with an equal tag (address bits [9:4]) raises `cpu_ready` in the same cycle as `cpu_req`, returns the stored word and makes no bus transfer.
- R3: A load that misses raises `bus_req` and waits for `bus_gnt`, then drives a read with `bus_valid` high and `bus_we` low. It completes in the cycle `bus_ack` is high, returns `bus_rdata` on `cpu_rdata` and fills the line as valid.
- R4: Every store raises `bus_req`, waits for `bus_gnt`, and drives exactly one bus write with `bus_we` high carrying its address and data. `cpu_ready` for a store is high only in the cycle the write is acknowledged, and the processor is stalled until then.
- R5: A store to a valid line with a matching tag also writes the new word into that line, which stays valid, so a following load hits and returns the stored word.
- R6: A store that misses does not allocate, so a following load of that address misses and fetches the value from memory.
- R7: A snooped write (`snp_valid` and `snp_we` high, `snp_id` not equal to MY_ID) whose address matches a valid line invalidates it. A later local load of that address misses and returns the value now in memory.
- R8: A snooped write whose `snp_id` equals MY_ID leaves every line unchanged, so a following load of that address still hits.
- R9: A snooped read (`snp_we` low), or a snooped write to the same index with a different tag, leaves the line valid.
- R10: A snoop kill of a line in the same cycle as a local access to it takes effect first. A load presented in that cycle is handled as a miss, and a store hit acknowledged in that cycle leaves the line invalid.
- R11: `bus_valid` rises only after `bus_gnt` has been seen, `bus_req` stays high while `bus_valid` is high, and address, direction and data are stable until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 10 | Word address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| bus_valid | output | 1 | Transfer driven on the bus |
| bus_we | output | 1 | Transfer is a write |
| bus_addr | output | 10 | Transfer word address |
| bus_wdata | output | 32 | Transfer write data |
| bus_ack | input | 1 | Memory accepts the transfer this cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| snp_valid | input | 1 | A transfer by some master is on the bus |
| snp_we | input | 1 | The observed transfer is a write |
| snp_id | input | 2 | Master number of the observed transfer |
| snp_addr | input | 10 | Word address of the observed transfer |

## Verification
The hardest case to reach is the kill of a line in the cycle its own store is acknowledged. From the ports, that cycle is fixed only by the memory side. To hit it, the bench's bus responder holds a pending snoop and releases it in the same edge that raises `bus_ack`. A later load must then miss even though the store had hit. The same-cycle kill of a load hit is reached by releasing a snoop on the edge that presents the load. Grant and acknowledge delays are varied between accesses so that stall lengths differ.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int LINES  = 16;
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef enum logic [1:0] {ST_IDLE, ST_ARB, ST_XFER} state_t;

    typedef struct packed {
        logic  we;
        addr_t addr;
        data_t wdata;
    } cpu_op_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        tag_t  tag;
        data_t data;
    } line_wr_t;

    function automatic idx_t idx_of(input addr_t a);
        return a[IDX_W-1:0];
    endfunction

    function automatic tag_t tag_of(input addr_t a);
        return a[ADDR_W-1:IDX_W];
    endfunction
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store
    import wtc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  idx_t     a_idx,
    output logic     a_valid,
    output tag_t     a_tag,
    output data_t    a_data,
    input  idx_t     s_idx,
    output logic     s_valid,
    output tag_t     s_tag,
    input  line_wr_t wr,
    input  logic     inv_en,
    input  idx_t     inv_idx
);
    logic [LINES-1:0] valid_q;
    tag_t             tag_q  [LINES];
    data_t            data_q [LINES];

    // valid bits: a kill beats a fill or update on the same line
    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                valid_q[i] <= 1'b0;
            else if (inv_en && inv_idx == idx_t'(i))
                valid_q[i] <= 1'b0;
            else if (wr.en && wr.idx == idx_t'(i))
                valid_q[i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr.en) begin
            tag_q[wr.idx]  <= wr.tag;
            data_q[wr.idx] <= wr.data;
        end
    end

    assign a_valid = valid_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = data_q[a_idx];
    assign s_valid = valid_q[s_idx];
    assign s_tag   = tag_q[s_idx];
endmodule

// File: rtl/wtc_snoop.sv
module wtc_snoop
    import wtc_pkg::*;
#(
    parameter int ID_W  = 2,
    parameter int MY_ID = 0
) (
    input  logic            snp_valid,
    input  logic            snp_we,
    input  logic [ID_W-1:0] snp_id,
    input  addr_t           snp_addr,
    output idx_t            s_idx,
    input  logic            s_valid,
    input  tag_t            s_tag,
    output logic            inv_en,
    output idx_t            inv_idx
);
    logic foreign_wr;

    assign foreign_wr = snp_valid && snp_we && (snp_id != ID_W'(MY_ID));
    assign s_idx      = idx_of(snp_addr);
    assign inv_idx    = s_idx;
    assign inv_en     = foreign_wr && s_valid && (s_tag == tag_of(snp_addr));
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cpu_req,
    input  logic     cpu_we,
    input  addr_t    cpu_addr,
    input  data_t    cpu_wdata,
    output logic     cpu_ready,
    output data_t    cpu_rdata,
    output logic     bus_req,
    input  logic     bus_gnt,
    output logic     bus_valid,
    output logic     bus_we,
    output addr_t    bus_addr,
    output data_t    bus_wdata,
    input  logic     bus_ack,
    input  data_t    bus_rdata,
    output idx_t     a_idx,
    input  logic     a_valid,
    input  tag_t     a_tag,
    input  data_t    a_data,
    input  logic     inv_en,
    input  idx_t     inv_idx,
    output line_wr_t wr
);
    state_t  state_q, state_d;
    cpu_op_t op_q;
    tag_t    cur_tag;
    logic    killed, hit;

    assign a_idx   = (state_q == ST_IDLE) ? idx_of(cpu_addr) : idx_of(op_q.addr);
    assign cur_tag = (state_q == ST_IDLE) ? tag_of(cpu_addr) : tag_of(op_q.addr);
    assign killed  = inv_en && (inv_idx == a_idx);
    assign hit     = a_valid && (a_tag == cur_tag) && !killed;

    assign bus_we    = op_q.we;
    assign bus_addr  = op_q.addr;
    assign bus_wdata = op_q.wdata;

    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        cpu_rdata = a_data;
        bus_req   = 1'b0;
        bus_valid = 1'b0;
        wr        = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (!cpu_we && hit) cpu_ready = 1'b1;
                    else                state_d   = ST_ARB;
                end
            end
            ST_ARB: begin
                bus_req = 1'b1;
                if (bus_gnt) state_d = ST_XFER;
            end
            ST_XFER: begin
                bus_req   = 1'b1;
                bus_valid = 1'b1;
                if (bus_ack) begin
                    cpu_ready = 1'b1;
                    state_d   = ST_IDLE;
                    if (!op_q.we) begin
                        cpu_rdata = bus_rdata;
                        wr        = '{en: 1'b1, idx: a_idx, tag: cur_tag, data: bus_rdata};
                    end else if (hit) begin
                        wr        = '{en: 1'b1, idx: a_idx, tag: cur_tag, data: op_q.wdata};
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_req)
                op_q <= '{we: cpu_we, addr: cpu_addr, wdata: cpu_wdata};
        end
    end
endmodule

// File: rtl/wtsnoop_cache.sv
module wtsnoop_cache
    import wtc_pkg::*;
#(
    parameter int ID_W  = 2,
    parameter int MY_ID = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [wtc_pkg::ADDR_W-1:0] cpu_addr,
    input  logic [wtc_pkg::DATA_W-1:0] cpu_wdata,
    output logic                     cpu_ready,
    output logic [wtc_pkg::DATA_W-1:0] cpu_rdata,
    output logic                     bus_req,
    input  logic                     bus_gnt,
    output logic                     bus_valid,
    output logic                     bus_we,
    output logic [wtc_pkg::ADDR_W-1:0] bus_addr,
    output logic [wtc_pkg::DATA_W-1:0] bus_wdata,
    input  logic                     bus_ack,
    input  logic [wtc_pkg::DATA_W-1:0] bus_rdata,
    input  logic                     snp_valid,
    input  logic                     snp_we,
    input  logic [ID_W-1:0]          snp_id,
    input  logic [wtc_pkg::ADDR_W-1:0] snp_addr
);
    idx_t     a_idx, s_idx, inv_idx;
    logic     a_valid, s_valid, inv_en;
    tag_t     a_tag, s_tag;
    data_t    a_data;
    line_wr_t wr;

    wtc_line_store u_store (
        .clk(clk), .rst(rst),
        .a_idx(a_idx), .a_valid(a_valid), .a_tag(a_tag), .a_data(a_data),
        .s_idx(s_idx), .s_valid(s_valid), .s_tag(s_tag),
        .wr(wr), .inv_en(inv_en), .inv_idx(inv_idx)
    );

    wtc_snoop #(.ID_W(ID_W), .MY_ID(MY_ID)) u_snoop (
        .snp_valid(snp_valid), .snp_we(snp_we), .snp_id(snp_id), .snp_addr(snp_addr),
        .s_idx(s_idx), .s_valid(s_valid), .s_tag(s_tag),
        .inv_en(inv_en), .inv_idx(inv_idx)
    );

    wtc_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .a_idx(a_idx), .a_valid(a_valid), .a_tag(a_tag), .a_data(a_data),
        .inv_en(inv_en), .inv_idx(inv_idx), .wr(wr)
    );
endmodule

// File: rtl/wtsnoop_cache_chk.sv
module wtsnoop_cache_chk #(
    parameter int ID_W   = 2,
    parameter int MY_ID  = 0,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              snp_valid,
    input logic              snp_we,
    input logic [ID_W-1:0]   snp_id,
    input logic              inv_en
);
    assert_req_held_R11: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> bus_req);

    assert_grant_first_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_valid) |-> $past(bus_gnt));

    assert_xfer_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    assert_store_through_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_we) |-> (bus_valid && bus_we && bus_ack && bus_addr == cpu_addr));

    assert_ready_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> cpu_req);

    assert_own_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_id == ID_W'(MY_ID)) |-> !inv_en);

    assert_read_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && !snp_we) |-> !inv_en);
endmodule

bind wtsnoop_cache wtsnoop_cache_chk #(.ID_W(ID_W), .MY_ID(MY_ID)) u_chk (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_id(snp_id), .inv_en(inv_en)
);

// File: tb/test_wtsnoop_cache.sv
module test_wtsnoop_cache;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int ME = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 0, cpu_we = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req, bus_valid, bus_we;
    logic          bus_gnt = 0, bus_ack = 0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata = '0;
    logic          snp_valid = 0, snp_we = 0;
    logic [1:0]    snp_id = '0;
    logic [AW-1:0] snp_addr = '0;

    wtsnoop_cache #(.ID_W(2), .MY_ID(ME)) i_wtsnoop_cache (.*);

    always #5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;

    // behavioural memory and reference cache
    logic [DW-1:0] mem [int];
    bit            rv [16];
    logic [5:0]    rt [16];
    logic [DW-1:0] rd [16];

    function automatic logic [DW-1:0] memrd(input logic [AW-1:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 32'hA500_0000 ^ (32'(a) * 32'd17);
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bus responder and snoop injector
    int gnt_delay = 0, ack_delay = 0, gcnt = 0, acnt = 0;
    int nwr = 0, nbus = 0;
    logic [AW-1:0] last_waddr;
    logic [DW-1:0] last_wdata;
    bit            sq_req = 0, sq_on_ack = 0, sq_mem = 0, sq_we = 0;
    logic [1:0]    sq_id;
    logic [AW-1:0] sq_addr;
    logic [DW-1:0] sq_data;

    always @(posedge clk) begin
        bit set_ack;
        set_ack = 1'b0;
        if (rst) begin
            bus_gnt <= 0; bus_ack <= 0; snp_valid <= 0; gcnt = 0; acnt = 0;
        end else begin
            if (bus_req && !bus_valid) begin
                bus_gnt <= (gcnt >= gnt_delay);
                gcnt++;
            end else begin
                bus_gnt <= 0; gcnt = 0;
            end
            if (bus_valid && bus_ack) begin
                nbus++;
                if (bus_we) begin
                    mem[int'(bus_addr)] = bus_wdata;
                    nwr++; last_waddr = bus_addr; last_wdata = bus_wdata;
                end
                bus_ack <= 0; acnt = 0;
            end else if (bus_valid) begin
                if (acnt >= ack_delay) begin
                    set_ack = 1'b1;
                    bus_ack <= 1; bus_rdata <= memrd(bus_addr);
                end
                acnt++;
            end else begin
                bus_ack <= 0; acnt = 0;
            end
            if (sq_req && (!sq_on_ack || set_ack)) begin
                snp_valid <= 1; snp_we <= sq_we; snp_id <= sq_id; snp_addr <= sq_addr;
                sq_req = 0;
                if (sq_we && sq_id != 2'(ME) && rv[sq_addr[3:0]] && rt[sq_addr[3:0]] == sq_addr[9:4])
                    rv[sq_addr[3:0]] = 0;
                if (sq_mem) mem[int'(sq_addr)] = sq_data;
            end else begin
                snp_valid <= 0;
            end
        end
    end

    // per-cycle comparison of protocol rules
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            check(!(cpu_ready && !cpu_req), "R2 ready without request", DW'(cpu_ready), 0);
            check(!(bus_valid && !bus_req), "R11 valid without req", DW'(bus_req), 1);
            if (cpu_ready && cpu_we)
                check(bus_valid && bus_ack && bus_we, "R4 store ready without bus ack", DW'(bus_ack), 1);
            if (cyc > 20000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    task automatic snoop(input bit we, input logic [1:0] id, input logic [AW-1:0] a,
                         input bit upd, input logic [DW-1:0] d, input bit on_ack);
        sq_we = we; sq_id = id; sq_addr = a; sq_mem = upd; sq_data = d; sq_on_ack = on_ack;
        sq_req = 1;
    endtask

    task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input int gd, input int ad, input string req);
        int lat;
        int wr0, bus0;
        bit exp_hit;
        logic [DW-1:0] exp_d, got;
        gnt_delay = gd; ack_delay = ad;
        wr0 = nwr; bus0 = nbus;
        @(posedge clk);
        cpu_req <= 1; cpu_we <= we; cpu_addr <= a; cpu_wdata <= wd;
        @(negedge clk);
        exp_hit = !we && rv[a[3:0]] && rt[a[3:0]] == a[9:4];
        lat = 1;
        while (!cpu_ready && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        got = cpu_rdata;
        exp_d = exp_hit ? rd[a[3:0]] : memrd(a);
        @(posedge clk);
        cpu_req <= 0;
        #1;
        if (we) begin
            check(lat > gd + 1, {req, " store stalled until grant"}, DW'(lat), DW'(gd + 2));
            check(nwr == wr0 + 1 && last_waddr == a && last_wdata == wd,
                  {req, " store written through"}, last_wdata, wd);
            if (rv[a[3:0]] && rt[a[3:0]] == a[9:4]) rd[a[3:0]] = wd;
        end else begin
            check((lat == 1) == exp_hit, {req, exp_hit ? " expected hit" : " expected miss"},
                  DW'(lat), DW'(exp_hit));
            check(got == exp_d, {req, " load data"}, got, exp_d);
            if (exp_hit)
                check(nbus == bus0, {req, " hit made no bus transfer"}, DW'(nbus - bus0), 0);
            else begin
                rv[a[3:0]] = 1; rt[a[3:0]] = a[9:4]; rd[a[3:0]] = exp_d;
            end
        end
    endtask

    localparam logic [AW-1:0] A = 10'h013;
    localparam logic [AW-1:0] B = 10'h023;
    localparam logic [AW-1:0] C = 10'h045;

    initial begin
        for (int i = 0; i < 16; i++) rv[i] = 0;
        repeat (3) @(posedge clk);
        rst <= 0;
        @(negedge clk);
        check(!cpu_ready && !bus_req && !bus_valid, "R1 reset outputs idle",
              {29'd0, cpu_ready, bus_req, bus_valid}, 0);

        access(0, A, 0, 0, 0, "R1 R3 first load");
        access(0, A, 0, 0, 0, "R2 repeat load");
        access(1, A, 32'h1111_1111, 2, 1, "R4 R5 store hit");
        access(0, A, 0, 0, 0, "R5 load after store hit");
        access(1, C, 32'h5555_0000, 0, 2, "R6 store miss");
        access(0, C, 0, 1, 0, "R6 load after store miss");

        snoop(1, 2'(ME), A, 0, 0, 0);
        access(0, A, 0, 0, 0, "R8 own snoop ignored");
        snoop(1, 2'd2, B, 0, 0, 0);
        access(0, A, 0, 0, 0, "R9 other tag snoop ignored");
        snoop(0, 2'd2, A, 0, 0, 0);
        access(0, A, 0, 0, 0, "R9 snooped read ignored");

        snoop(1, 2'd2, A, 1, 32'h2222_2222, 0);
        repeat (2) @(posedge clk);
        access(0, A, 0, 3, 2, "R7 load after snoop kill");
        access(0, A, 0, 0, 0, "R7 refill hits");

        snoop(1, 2'd0, A, 1, 32'h3333_3333, 0);
        access(0, A, 0, 0, 1, "R10 same-cycle kill of load hit");

        snoop(1, 2'd3, A, 0, 0, 1);
        access(1, A, 32'h4444_4444, 1, 1, "R10 store hit killed at ack");
        access(0, A, 0, 0, 0, "R10 line left invalid");

        access(1, B, 32'h6666_6666, 5, 3, "R4 long stall store");
        access(0, B, 0, 4, 4, "R3 long miss");
        access(0, B, 0, 0, 0, "R2 hit after long miss");

        repeat (3) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule